// File: doc/BRIEF.md
# Slot Expansion-ROM Override Controller

This block watches the address, read/write and phase-0 lines of an 8-bit microcomputer bus with seven peripheral slots. A fast logic clock samples these lines. The block keeps three pieces of state:

- the number of the slot whose page was touched most recently;
- a flag that tells whether the machine is the enhanced model, found at run time;
- an override flag that takes the shared $C800-$CFFF expansion window away from every peripheral card.

From this state it drives an active-low expansion strobe. Cards use the strobe to decide whether to answer in the shared window.

The enhanced model writes to the soft-switch page within milliseconds of boot, and the base model never does. The first such write therefore marks the machine as enhanced. An access to the slot-3 page can take over the window, but only on the enhanced model and only while the slot-3 ROM select is 0. Touching any other slot page gives the window back, and so does touching $CFFF. A build parameter can force enhanced behaviour; detection is then skipped.

The block decodes bus events only while phase 0 is high. This way, address transients between bus phases cannot change its state.

Top module: `slot_rom_ctrl`

## Requirements
- R1: After synchronous reset `ovr_active`=0, `last_slot`=0, `exp_strobe_n`=1, and `enh_model`=0 (1 when FORCE_ENH=1).
- R2: A write (`bus_rd`=0) to $C000-$C00F sampled with phase 0 high sets `enh_model` on the next cycle. Reads of that range do not set it. Once set, it stays set until reset.
- R3: An access to page $C3 with `c3_rom_sel`=0 while `enh_model`=1 sets `ovr_active` on the next cycle.
- R4: While `enh_model`=0, an access to page $C3 never sets `ovr_active`.
- R5: An access to page $C3 with `c3_rom_sel`=1 leaves `ovr_active` unchanged.
- R6: An access to any slot page $C1xx, $C2xx or $C4xx-$C7xx clears `ovr_active` on the next cycle.
- R7: An access to address $CFFF clears `ovr_active` on the next cycle.
- R8: On any access to page $Csxx with s in 1..7, `last_slot` takes s on the next cycle. All other addresses, including page $C0, leave it unchanged.
- R9: `exp_strobe_n` goes low on the cycle after phase 0 is sampled high with an address in $C800-$CFFF while `ovr_active` is 0, judged by the value it had before that edge. Otherwise it is 1, so an active override suppresses the strobe for every slot.
- R10: When `bus_phi0` is sampled low, no state changes and `exp_strobe_n` is 1.
- R11: With FORCE_ENH=1, a $C3 access with `c3_rom_sel`=0 sets `ovr_active` without any soft-switch write, and a later access to another slot page clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast logic clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Bus address |
| bus_rd | input | 1 | 1 = read cycle, 0 = write cycle |
| bus_phi0 | input | 1 | Phase-0 clock of the bus |
| c3_rom_sel | input | 1 | Slot-3 ROM select switch; 0 selects the internal ROM |
| ovr_active | output | 1 | Expansion-window override flag |
| last_slot | output | 3 | Slot number of the most recent slot-page access |
| enh_model | output | 1 | Enhanced model detected (or forced) |
| exp_strobe_n | output | 1 | Active-low expansion-window strobe |

## Verification
The hardest state to reach is the override flag set while the model flag is also set. The bench only gets there after a soft-switch write during phase 0. Before that, the same $C3 access must be shown to have no effect.

The stimulus table runs a fixed order of steps:
1. $C3 accesses on the base model.
2. Phase-0-low writes that must be ignored, and a soft-switch read that must also be ignored.
3. The detecting write.
4. Override set and clear through another slot, through $CFFF, and with the select switch at 1.

Strobe checks fall on the same edge that clears the override. This shows that the strobe uses the flag value from before the clear.

// File: rtl/slot_rom_pkg.sv
package slot_rom_pkg;
  localparam int ADDR_W = 16;
  localparam int SLOT_W = 3;

  typedef struct packed {
    logic              slot_hit;
    logic [SLOT_W-1:0] slot_num;
    logic              sw_write;
    logic              in_window;
    logic              last_byte;
  } bus_evt_t;
endpackage

// File: rtl/slot_bus_decode.sv
module slot_bus_decode
  import slot_rom_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int SW = SLOT_W
) (
  input  logic [AW-1:0] addr,
  input  logic          rd,
  input  logic          phi0,
  output logic          slot_hit,
  output logic [SW-1:0] slot_num,
  output logic          sw_write,
  output logic          in_window,
  output logic          last_byte
);
  localparam logic [3:0]    IO_NIBBLE  = 4'hC;
  localparam logic [AW-5:0] SW_PAGE    = 12'hC00;
  localparam logic [4:0]    WIN_PREFIX = 5'b11001;
  localparam logic [AW-1:0] LAST_ADDR  = 16'hCFFF;

  logic io_space;
  assign io_space = (addr[AW-1:AW-4] == IO_NIBBLE);

  always_comb begin
    slot_hit  = phi0 && io_space && !addr[11] && (addr[10:8] != '0);
    slot_num  = addr[8+SW-1:8];
    sw_write  = phi0 && !rd && (addr[AW-1:4] == SW_PAGE);
    in_window = phi0 && (addr[AW-1:AW-5] == WIN_PREFIX);
    last_byte = phi0 && (addr == LAST_ADDR);
  end
endmodule

// File: rtl/slot_model_detect.sv
module slot_model_detect (
  input  logic clk,
  input  logic rst,
  input  logic sw_write,
  output logic enh_q
);
  always_ff @(posedge clk) begin
    if (rst)           enh_q <= 1'b0;
    else if (sw_write) enh_q <= 1'b1;
  end

  // R2: flag is sticky
  a_r2_sticky: assert property (@(posedge clk) disable iff (rst)
    enh_q |=> enh_q);
  // R2: set follows a soft-switch write
  a_r2_set_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(enh_q) |-> $past(sw_write));
endmodule

// File: rtl/slot_ovr_track.sv
module slot_ovr_track #(
  parameter int SW       = 3,
  parameter int OVR_SLOT = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          slot_hit,
  input  logic [SW-1:0] slot_num,
  input  logic          last_byte,
  input  logic          enh,
  input  logic          c3_sel,
  output logic          ovr_q,
  output logic [SW-1:0] last_q
);
  localparam logic [SW-1:0] OVR_ID = SW'(OVR_SLOT);

  logic own_page, other_page;
  assign own_page   = slot_hit && (slot_num == OVR_ID);
  assign other_page = slot_hit && (slot_num != OVR_ID);

  always_ff @(posedge clk) begin
    if (rst) begin
      ovr_q <= 1'b0;
    end else if (other_page || last_byte) begin
      ovr_q <= 1'b0;
    end else if (own_page && !c3_sel && enh) begin
      ovr_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           last_q <= '0;
    else if (slot_hit) last_q <= slot_num;
  end

  a_r4_needs_enh: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr_q) |-> $past(enh));
  a_r5_sel_holds: assert property (@(posedge clk) disable iff (rst)
    (own_page && c3_sel) |=> $stable(ovr_q));
  a_r6_other_clears: assert property (@(posedge clk) disable iff (rst)
    other_page |=> !ovr_q);
  a_r7_last_clears: assert property (@(posedge clk) disable iff (rst)
    last_byte |=> !ovr_q);
  a_r8_slot_record: assert property (@(posedge clk) disable iff (rst)
    slot_hit |=> (last_q == $past(slot_num)));
  a_r8_slot_nonzero: assert property (@(posedge clk) disable iff (rst)
    slot_hit |-> (slot_num != '0));
endmodule

// File: rtl/slot_strobe_gen.sv
module slot_strobe_gen (
  input  logic clk,
  input  logic rst,
  input  logic in_window,
  input  logic ovr,
  output logic strobe_n_q
);
  always_ff @(posedge clk) begin
    if (rst) strobe_n_q <= 1'b1;
    else     strobe_n_q <= !(in_window && !ovr);
  end

  // R9: an override in force blocks the strobe on the next cycle
  a_r9_blocked: assert property (@(posedge clk) disable iff (rst)
    ovr |=> strobe_n_q);
endmodule

// File: rtl/slot_rom_ctrl.sv
module slot_rom_ctrl
  import slot_rom_pkg::*;
#(
  parameter int AW        = ADDR_W,
  parameter int SW        = SLOT_W,
  parameter int OVR_SLOT  = 3,
  parameter bit FORCE_ENH = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_rd,
  input  logic          bus_phi0,
  input  logic          c3_rom_sel,
  output logic          ovr_active,
  output logic [SW-1:0] last_slot,
  output logic          enh_model,
  output logic          exp_strobe_n
);
  bus_evt_t evt;
  logic     enh;

  slot_bus_decode #(.AW(AW), .SW(SW)) u_dec (
    .addr      (bus_addr),
    .rd        (bus_rd),
    .phi0      (bus_phi0),
    .slot_hit  (evt.slot_hit),
    .slot_num  (evt.slot_num),
    .sw_write  (evt.sw_write),
    .in_window (evt.in_window),
    .last_byte (evt.last_byte)
  );

  generate
    if (FORCE_ENH) begin : g_forced
      logic unused_sw;
      assign unused_sw = evt.sw_write;
      assign enh       = 1'b1;
    end else begin : g_detect
      slot_model_detect u_det (
        .clk      (clk),
        .rst      (rst),
        .sw_write (evt.sw_write),
        .enh_q    (enh)
      );
    end
  endgenerate

  slot_ovr_track #(.SW(SW), .OVR_SLOT(OVR_SLOT)) u_ovr (
    .clk       (clk),
    .rst       (rst),
    .slot_hit  (evt.slot_hit),
    .slot_num  (evt.slot_num),
    .last_byte (evt.last_byte),
    .enh       (enh),
    .c3_sel    (c3_rom_sel),
    .ovr_q     (ovr_active),
    .last_q    (last_slot)
  );

  slot_strobe_gen u_stb (
    .clk        (clk),
    .rst        (rst),
    .in_window  (evt.in_window),
    .ovr        (ovr_active),
    .strobe_n_q (exp_strobe_n)
  );

  assign enh_model = enh;

  // R10: with phase 0 low nothing moves and the strobe stays high
  a_r10_idle: assert property (@(posedge clk) disable iff (rst)
    !bus_phi0 |=> ($stable(ovr_active) && $stable(last_slot) && exp_strobe_n));
  // R9: a strobe implies the override was clear
  a_r9_strobe_src: assert property (@(posedge clk) disable iff (rst)
    !exp_strobe_n |-> $past(!ovr_active && bus_phi0));
endmodule

// File: tb/sim_slot_rom_ctrl.sv
module sim_slot_rom_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] addr = 16'h0000;
  logic        rd = 1'b1, phi = 1'b0, sel = 1'b0;
  logic        ovr0, enh0, stb0, ovr1, enh1, stb1;
  logic [2:0]  last0, last1;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  slot_rom_ctrl u0 (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_rd(rd), .bus_phi0(phi),
    .c3_rom_sel(sel), .ovr_active(ovr0), .last_slot(last0),
    .enh_model(enh0), .exp_strobe_n(stb0));

  slot_rom_ctrl #(.FORCE_ENH(1'b1)) u1 (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_rd(rd), .bus_phi0(phi),
    .c3_rom_sel(sel), .ovr_active(ovr1), .last_slot(last1),
    .enh_model(enh1), .exp_strobe_n(stb1));

  // {addr, rd, phi0, sel, exp ovr, exp last, exp model, exp strobe_n}
  localparam int NV = 19;
  localparam logic [24:0] VEC [NV] = '{
    {16'hC300,1'b1,1'b1,1'b0, 1'b0,3'd3,1'b0,1'b1}, // R4 base model
    {16'hC800,1'b1,1'b1,1'b0, 1'b0,3'd3,1'b0,1'b0}, // R9 strobe
    {16'hC005,1'b0,1'b0,1'b0, 1'b0,3'd3,1'b0,1'b1}, // R10 phi0 low
    {16'hC005,1'b1,1'b1,1'b0, 1'b0,3'd3,1'b0,1'b1}, // R2 read ignored
    {16'hC005,1'b0,1'b1,1'b0, 1'b0,3'd3,1'b1,1'b1}, // R2 detect
    {16'hC300,1'b1,1'b1,1'b0, 1'b1,3'd3,1'b1,1'b1}, // R3 set
    {16'hCA00,1'b1,1'b1,1'b0, 1'b1,3'd3,1'b1,1'b1}, // R9 suppressed
    {16'hC600,1'b1,1'b0,1'b0, 1'b1,3'd3,1'b1,1'b1}, // R10 ignored
    {16'hC600,1'b1,1'b1,1'b0, 1'b0,3'd6,1'b1,1'b1}, // R6 clear
    {16'hC300,1'b1,1'b1,1'b1, 1'b0,3'd3,1'b1,1'b1}, // R5 sel=1
    {16'hC300,1'b1,1'b1,1'b0, 1'b1,3'd3,1'b1,1'b1}, // R3
    {16'hC3FF,1'b1,1'b1,1'b1, 1'b1,3'd3,1'b1,1'b1}, // R5 holds set
    {16'hCFFF,1'b1,1'b1,1'b0, 1'b0,3'd3,1'b1,1'b1}, // R7, R9 old flag
    {16'hCFFF,1'b1,1'b1,1'b0, 1'b0,3'd3,1'b1,1'b0}, // R9
    {16'hC300,1'b1,1'b1,1'b0, 1'b1,3'd3,1'b1,1'b1}, // R3
    {16'hC100,1'b0,1'b1,1'b0, 1'b0,3'd1,1'b1,1'b1}, // R6 write
    {16'hC700,1'b1,1'b1,1'b0, 1'b0,3'd7,1'b1,1'b1}, // R8
    {16'hC000,1'b1,1'b1,1'b0, 1'b0,3'd7,1'b1,1'b1}, // R8 page C0
    {16'h2000,1'b0,1'b1,1'b0, 1'b0,3'd7,1'b1,1'b1}  // R8 other
  };

  task automatic check(input string req, input string what,
                       input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] a, input logic r, input logic p,
                       input logic s);
    @(negedge clk);
    addr = a; rd = r; phi = p; sel = s;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; phi = 1'b0; addr = 16'h0000; rd = 1'b1; sel = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    do_reset();
    check("R1", "ovr", {3'b0, ovr0}, 4'h0);
    check("R1", "last", {1'b0, last0}, 4'h0);
    check("R1", "model", {3'b0, enh0}, 4'h0);
    check("R1", "strobe_n", {3'b0, stb0}, 4'h1);
    check("R1", "forced model", {3'b0, enh1}, 4'h1);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      addr = VEC[i][24:9]; rd = VEC[i][8]; phi = VEC[i][7]; sel = VEC[i][6];
      @(negedge clk);
      check($sformatf("vec%0d", i), "ovr",      {3'b0, ovr0},  {3'b0, VEC[i][5]});
      check($sformatf("vec%0d", i), "last",     {1'b0, last0}, {1'b0, VEC[i][4:2]});
      check($sformatf("vec%0d", i), "model",    {3'b0, enh0},  {3'b0, VEC[i][1]});
      check($sformatf("vec%0d", i), "strobe_n", {3'b0, stb0},  {3'b0, VEC[i][0]});
    end

    // R1: reset mid-run clears everything again
    do_reset();
    check("R1", "ovr after rerun", {3'b0, ovr0}, 4'h0);
    check("R1", "model after rerun", {3'b0, enh0}, 4'h0);
    check("R1", "last after rerun", {1'b0, last0}, 4'h0);

    // R11: forced instance takes the window with no soft-switch write
    drive(16'hC300, 1'b1, 1'b1, 1'b0);
    check("R11", "forced set", {3'b0, ovr1}, 4'h1);
    check("R4", "base still clear", {3'b0, ovr0}, 4'h0);
    drive(16'hCC00, 1'b1, 1'b1, 1'b0);
    check("R11", "forced strobe blocked", {3'b0, stb1}, 4'h1);
    check("R9", "base strobe low", {3'b0, stb0}, 4'h0);
    drive(16'hC200, 1'b1, 1'b1, 1'b0);
    check("R11", "forced clear", {3'b0, ovr1}, 4'h0);
    check("R8", "slot 2", {1'b0, last1}, 4'h2);

    // R2: top of the soft-switch range detects, just above it does not
    drive(16'hC010, 1'b0, 1'b1, 1'b0);
    check("R2", "C010 no detect", {3'b0, enh0}, 4'h0);
    drive(16'hC00F, 1'b0, 1'b1, 1'b0);
    check("R2", "C00F detect", {3'b0, enh0}, 4'h1);

    // R10: window access with phase 0 low gives no strobe
    drive(16'hC900, 1'b1, 1'b0, 1'b0);
    check("R10", "strobe idle", {3'b0, stb0}, 4'h1);
    // R9: window boundary $C7FF is not in the window
    drive(16'hC7FF, 1'b1, 1'b1, 1'b0);
    check("R9", "C7FF no strobe", {3'b0, stb0}, 4'h1);
    check("R8", "C7FF slot 7", {1'b0, last0}, 4'h7);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule